// File: doc/BRIEF.md
# I2C Slave Receive Engine with Address Recognition

This block lets a chip act as a write target on a two-wire I2C bus. It oversamples SCL and SDA with the system clock and detects START and STOP conditions. It shifts in the address byte and compares it with a programmable own address. It can also accept the general call address 0x00. When the address matches in the write direction and acknowledge is enabled, the block pulls SDA low during the ninth clock. It then reports an event with a status code and goes on to receive data bytes, most significant bit first.

Each event is presented on a valid/ready output. `evt_valid` acts as the interrupt flag. While it is high, the block holds SCL low, so the bus master is stretched until the host accepts the event by raising `evt_ready`. This is the only back-pressure: the bus cannot advance while an event is pending, so no event is ever lost or overwritten. `evt_status` and `evt_data` stay stable until the handshake. `evt_valid` drops in the cycle after `evt_valid && evt_ready`. The host drives `cfg_adr`, `ctl_en` and `ctl_aa` as plain levels.

Top module: `i2c_srx`

## Requirements
- R1: After reset, `evt_valid`, `sda_oe` and `scl_oe` are 0 and `evt_status` reads 0xF8.
- R2: With `ctl_en`=1 and `ctl_aa`=1, a nonzero address byte is matched when its bits 7:1 equal `cfg_adr[7:1]` and its bit 0 (direction) is 0. On a match the block pulls SDA low in the ninth clock and raises an event with status 0x60 and `evt_data` equal to the address byte.
- R3: The byte 0x00 is accepted as a general call only when `cfg_adr[0]`=1. It is then ACKed with event status 0x70. When `cfg_adr[0]`=0 it is not ACKed and raises no event.
- R4: An address byte that does not match, or whose direction bit is 1, is not ACKed and raises no event. The bytes that follow it are ignored until the next START.
- R5: With `ctl_aa`=0, a matching address is not ACKed and raises no event.
- R6: After an ACKed address, each data byte raises an event whose `evt_data` holds the byte. `ctl_aa` is sampled at the end of the byte's eighth bit. For an own-address transfer the status is 0x80 when ACKed and 0x88 when not ACKed. For a general call transfer the status is 0x90 when ACKed and 0x98 when not ACKed.
- R7: After a data byte that was not ACKed, the block is no longer addressed. Further bytes are not ACKed and raise no event, and a following STOP raises no event.
- R8: A STOP or a repeated START seen while the block is addressed raises an event with status 0xA0. A repeated START then proceeds to address reception.
- R9: While `evt_valid`=1 and `evt_ready`=0, SCL is held low and `evt_valid`, `evt_status` and `evt_data` stay stable. After `evt_valid && evt_ready`, `evt_valid` is 0 in the next cycle.
- R10: `evt_status` reads 0xF8 whenever `evt_valid`=0.
- R11: With `ctl_en`=0 the block never drives SDA or SCL and raises no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_oe | output | 1 | 1 pulls SDA low (acknowledge) |
| cfg_adr | input | 8 | Own address in bits 7:1, general call enable in bit 0 |
| ctl_en | input | 1 | Block enable |
| ctl_aa | input | 1 | Acknowledge enable |
| evt_valid | output | 1 | Event pending (interrupt flag) |
| evt_ready | input | 1 | Host accepts the event |
| evt_status | output | 8 | Status code of the pending event, 0xF8 if none |
| evt_data | output | 8 | Received address or data byte of the event |

## Verification
The bench uses the default two-stage line synchronizer and a bus phase of eight system clocks. Every SCL and SDA edge therefore settles in the block well inside one bus phase. With that margin, the acknowledge pulse can be sampled by the modelled master in mid-phase, and clock stretching can be observed on the wired-AND SCL line. The own address 0x2D is used with general call enabled and disabled. This covers the 0x00 corner and an address that differs only in its direction bit.

// File: rtl/i2c_srx_pkg.sv
package i2c_srx_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CNT_W  = $clog2(BYTE_W + 2);

  typedef enum logic [7:0] {
    ST_OWN_ADR = 8'h60,
    ST_GC_ADR  = 8'h70,
    ST_OWN_ACK = 8'h80,
    ST_OWN_NAK = 8'h88,
    ST_GC_ACK  = 8'h90,
    ST_GC_NAK  = 8'h98,
    ST_BUS_END = 8'hA0,
    ST_NONE    = 8'hF8
  } srx_code_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ADDR,
    PH_DATA
  } srx_phase_e;
endpackage

// File: rtl/i2c_srx_sync.sv
module i2c_srx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  localparam int unsigned DEPTH = (STAGES < 2) ? 2 : STAGES;

  logic [DEPTH-1:0] scl_pipe, sda_pipe;
  logic             scl_d, sda_d, scl_s;

  // idle bus is high: reset the pipes to 1 so no false START appears
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[DEPTH-2:0], scl_i};
      sda_pipe <= {sda_pipe[DEPTH-2:0], sda_i};
      scl_d    <= scl_s;
      sda_d    <= sda_s;
    end
  end

  assign scl_s     = scl_pipe[DEPTH-1];
  assign sda_s     = sda_pipe[DEPTH-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign bus_start = scl_s & scl_d & sda_d & ~sda_s;
  assign bus_stop  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_srx_match.sv
module i2c_srx_match
  import i2c_srx_pkg::*;
(
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic [BYTE_W-1:0] cfg_adr,
  output logic              own_hit,
  output logic              gc_hit
);
  logic byte_zero;

  assign byte_zero = (rx_byte == '0);
  // 0x00 is only ever a general call, never an own address
  assign gc_hit    = byte_zero & cfg_adr[0];
  assign own_hit   = ~byte_zero & ~rx_byte[0] &
                     (rx_byte[BYTE_W-1:1] == cfg_adr[BYTE_W-1:1]);
endmodule

// File: rtl/i2c_srx.sv
module i2c_srx
  import i2c_srx_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic [BYTE_W-1:0] cfg_adr,
  input  logic              ctl_en,
  input  logic              ctl_aa,
  output logic              evt_valid,
  input  logic              evt_ready,
  output logic [BYTE_W-1:0] evt_status,
  output logic [BYTE_W-1:0] evt_data
);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_ACK  = CNT_W'(BYTE_W + 1);

  logic              sda_s, scl_rise, scl_fall, bus_start, bus_stop;
  logic              own_hit, gc_hit;
  srx_phase_e        phase_q;
  logic [CNT_W-1:0]  bitcnt_q;
  logic [BYTE_W-1:0] shreg_q, data_q;
  srx_code_e         code_q;
  logic              ack_q, gc_q, si_q;

  i2c_srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .bus_start(bus_start),
    .bus_stop (bus_stop)
  );

  i2c_srx_match u_match (
    .rx_byte(shreg_q),
    .cfg_adr(cfg_adr),
    .own_hit(own_hit),
    .gc_hit (gc_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      bitcnt_q <= '0;
      shreg_q  <= '0;
      data_q   <= '0;
      code_q   <= ST_NONE;
      ack_q    <= 1'b0;
      gc_q     <= 1'b0;
      si_q     <= 1'b0;
    end else if (!ctl_en) begin
      phase_q  <= PH_IDLE;
      bitcnt_q <= '0;
      ack_q    <= 1'b0;
      si_q     <= 1'b0;
    end else begin
      if (si_q && evt_ready) si_q <= 1'b0;

      if (bus_stop || bus_start) begin
        // bus boundary while addressed is reported to the host
        if (phase_q == PH_DATA) begin
          si_q   <= 1'b1;
          code_q <= ST_BUS_END;
        end
        phase_q  <= bus_start ? PH_ADDR : PH_IDLE;
        bitcnt_q <= '0;
        ack_q    <= 1'b0;
      end else if (phase_q != PH_IDLE) begin
        if (scl_rise) begin
          bitcnt_q <= bitcnt_q + 1'b1;
          if (bitcnt_q < CNT_LAST) shreg_q <= {shreg_q[BYTE_W-2:0], sda_s};
        end
        if (scl_fall && bitcnt_q == CNT_LAST) begin
          data_q <= shreg_q;
          if (phase_q == PH_ADDR) begin
            if ((own_hit || gc_hit) && ctl_aa) begin
              ack_q <= 1'b1;
              gc_q  <= gc_hit;
            end else begin
              phase_q <= PH_IDLE;
            end
          end else begin
            ack_q <= ctl_aa;
          end
        end
        if (scl_fall && bitcnt_q == CNT_ACK) begin
          ack_q    <= 1'b0;
          bitcnt_q <= '0;
          si_q     <= 1'b1;
          if (phase_q == PH_ADDR) begin
            code_q  <= gc_q ? ST_GC_ADR : ST_OWN_ADR;
            phase_q <= PH_DATA;
          end else begin
            if (gc_q) code_q <= ack_q ? ST_GC_ACK : ST_GC_NAK;
            else      code_q <= ack_q ? ST_OWN_ACK : ST_OWN_NAK;
            if (!ack_q) phase_q <= PH_IDLE;
          end
        end
      end
    end
  end

  assign sda_oe     = ack_q;
  assign scl_oe     = si_q;
  assign evt_valid  = si_q;
  assign evt_status = si_q ? code_q : ST_NONE;
  assign evt_data   = data_q;
endmodule

// File: rtl/i2c_srx_chk.sv
module i2c_srx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       ctl_en,
  input logic       ctl_aa,
  input logic       evt_valid,
  input logic       evt_ready,
  input logic [7:0] evt_status,
  input logic [7:0] evt_data
);
  AST_HOLD_UNTIL_READY: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid && !evt_ready |=> evt_valid); // R9
  AST_PAYLOAD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid && !evt_ready |=> $stable(evt_status) && $stable(evt_data)); // R9
  AST_CLEAR_ON_READY: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid && evt_ready && ctl_en |=> !evt_valid); // R9
  AST_STRETCH_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> scl_oe && !sda_oe); // R9
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en |=> !sda_oe && !scl_oe && !evt_valid); // R11
  AST_ACK_NEEDS_AA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(ctl_aa)); // R5
  AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> evt_status inside {8'h60, 8'h70, 8'h80, 8'h88, 8'h90, 8'h98, 8'hA0}); // R6
endmodule

bind i2c_srx i2c_srx_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_oe    (scl_oe),
  .sda_oe    (sda_oe),
  .ctl_en    (ctl_en),
  .ctl_aa    (ctl_aa),
  .evt_valid (evt_valid),
  .evt_ready (evt_ready),
  .evt_status(evt_status),
  .evt_data  (evt_data)
);

// File: tb/i2c_srx_tb.sv
`timescale 1ns/1ps
module i2c_srx_tb;
  localparam int Q = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tb_scl = 1'b1, tb_sda = 1'b1;
  logic       scl_oe, sda_oe;
  logic [7:0] cfg_adr = 8'h5B;
  logic       ctl_en = 1'b1, ctl_aa = 1'b1;
  logic       evt_valid, evt_ready = 1'b0;
  logic [7:0] evt_status, evt_data;
  wire        bus_scl = tb_scl & ~scl_oe;
  wire        bus_sda = tb_sda & ~sda_oe;

  int checks = 0, fails = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  bit          done = 1'b0;

  always #10 clk = ~clk;

  i2c_srx u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(bus_scl), .sda_i(bus_sda),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .cfg_adr(cfg_adr),
    .ctl_en(ctl_en), .ctl_aa(ctl_aa), .evt_valid(evt_valid),
    .evt_ready(evt_ready), .evt_status(evt_status), .evt_data(evt_data)
  );

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic wait_q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic scl_high();
    tb_scl = 1'b1;
    wait (bus_scl == 1'b1);
    @(negedge clk);
  endtask

  task automatic bus_start();
    tb_sda = 1'b1; scl_high(); wait_q();
    tb_sda = 1'b0; wait_q();
    tb_scl = 1'b0; wait_q();
  endtask

  task automatic bus_rstart();
    tb_sda = 1'b1; wait_q();
    scl_high(); wait_q();
    tb_sda = 1'b0; wait_q();
    tb_scl = 1'b0; wait_q();
  endtask

  task automatic bus_stop();
    tb_sda = 1'b0; wait_q();
    scl_high(); wait_q();
    tb_sda = 1'b1; wait_q();
  endtask

  task automatic send(input logic [7:0] b, input bit exp_ack, input string req);
    bit acked;
    for (int i = 7; i >= 0; i--) begin
      tb_sda = b[i]; wait_q();
      scl_high(); wait_q();
      tb_scl = 1'b0; wait_q();
    end
    tb_sda = 1'b1; wait_q();
    scl_high();
    repeat (Q/2) @(negedge clk);
    acked = (bus_sda == 1'b0);
    repeat (Q/2) @(negedge clk);
    tb_scl = 1'b0; wait_q();
    check(acked == exp_ack, req, 16'(acked), 16'(exp_ack));
  endtask

  task automatic expect_evt(input logic [7:0] code, input logic [7:0] data, input string req);
    exp_q.push_back({code, data});
    tag_q.push_back(req);
  endtask

  // monitor: pops expected events and hands them back through evt_ready
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && evt_valid) begin
        logic [15:0] got, want;
        string tg;
        got = {evt_status, evt_data};
        if (exp_q.size() == 0) begin
          check(1'b0, "R4/R7 unexpected event", got, 16'h0000);
        end else begin
          want = exp_q.pop_front();
          tg = tag_q.pop_front();
          // bit 7:0 data only meaningful for non-A0 codes
          if (want[15:8] == 8'hA0) check(got[15:8] == 8'hA0, tg, got, want);
          else                     check(got == want, tg, got, want);
        end
        repeat (5) @(negedge clk);
        check(bus_scl == 1'b0 && evt_valid && {evt_status, evt_data} == got,
              "R9 hold while pending", {7'd0, bus_scl, evt_status}, {8'd0, got[15:8]});
        evt_ready = 1'b1;
        @(negedge clk);
        evt_ready = 1'b0;
        check(!evt_valid && evt_status == 8'hF8, "R10 cleared status",
              {7'd0, evt_valid, evt_status}, 16'h00F8);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!evt_valid && !sda_oe && !scl_oe && evt_status == 8'hF8, "R1 reset state",
          {5'd0, evt_valid, sda_oe, scl_oe, evt_status}, 16'h00F8);

    // own address with data, then STOP
    expect_evt(8'h60, 8'h5A, "R2 own address event");
    bus_start(); send(8'h5A, 1'b1, "R2 own address ack");
    expect_evt(8'h80, 8'h3C, "R6 own data acked");
    send(8'h3C, 1'b1, "R6 ack data");
    expect_evt(8'h80, 8'hC3, "R6 own data acked 2");
    send(8'hC3, 1'b1, "R6 ack data 2");
    expect_evt(8'hA0, 8'h00, "R8 stop while addressed");
    bus_stop();

    // general call, then NACKed data and ignored trailer
    expect_evt(8'h70, 8'h00, "R3 general call event");
    bus_start(); send(8'h00, 1'b1, "R3 general call ack");
    expect_evt(8'h90, 8'h11, "R6 gc data acked");
    send(8'h11, 1'b1, "R6 gc ack");
    ctl_aa = 1'b0;
    expect_evt(8'h98, 8'h22, "R6 gc data nacked");
    send(8'h22, 1'b0, "R6 gc nack");
    ctl_aa = 1'b1;
    send(8'h33, 1'b0, "R7 byte after nack ignored");
    bus_stop();

    // own address, NACKed data
    expect_evt(8'h60, 8'h5A, "R2 own address event 2");
    bus_start(); send(8'h5A, 1'b1, "R2 ack 2");
    ctl_aa = 1'b0;
    expect_evt(8'h88, 8'h99, "R6 own data nacked");
    send(8'h99, 1'b0, "R6 own nack");
    ctl_aa = 1'b1;
    bus_stop();

    // AA low on address
    ctl_aa = 1'b0;
    bus_start(); send(8'h5A, 1'b0, "R5 no ack with AA low");
    bus_stop();
    ctl_aa = 1'b1;

    // mismatch, followed by a byte that would match as address
    bus_start(); send(8'h5C, 1'b0, "R4 mismatch not acked");
    send(8'h5A, 1'b0, "R4 later byte ignored");
    bus_stop();

    // read direction
    bus_start(); send(8'h5B, 1'b0, "R4 read direction not acked");
    bus_stop();

    // general call disabled
    cfg_adr = 8'h5A;
    bus_start(); send(8'h00, 1'b0, "R3 general call ignored");
    bus_stop();

    // repeated start while addressed
    expect_evt(8'h60, 8'h5A, "R2 own address before rstart");
    bus_start(); send(8'h5A, 1'b1, "R2 ack before rstart");
    expect_evt(8'h80, 8'h77, "R6 data before rstart");
    send(8'h77, 1'b1, "R6 ack before rstart");
    expect_evt(8'hA0, 8'h00, "R8 repeated start event");
    bus_rstart();
    expect_evt(8'h60, 8'h5A, "R8 address after rstart");
    send(8'h5A, 1'b1, "R8 ack after rstart");
    expect_evt(8'hA0, 8'h00, "R8 final stop");
    bus_stop();

    // disabled block
    ctl_en = 1'b0;
    bus_start(); send(8'h5A, 1'b0, "R11 disabled no ack");
    bus_stop();
    check(!evt_valid && !scl_oe, "R11 disabled no event", {14'd0, evt_valid, scl_oe}, 16'h0000);
    ctl_en = 1'b1;

    repeat (40) @(negedge clk);
    check(exp_q.size() == 0, "R2 all expected events seen", 16'(exp_q.size()), 16'h0000);
    done = 1'b1;
    summary();
  end
endmodule